// File: doc/BRIEF.md
# Debug Line Target Bit Transmitter

This block sends one data bit from the target back to a debug host over a single shared open-drain wire. The host opens every bit slot by pulling the wire low. The target sees this falling edge only after the edge passes through a synchronizer, which takes up to one extra clock cycle. From that point the block counts target clock cycles and shapes the wire so that the host reads the right level when it samples, about ten cycles into the slot.

To send a one, the block leaves the wire undriven. The pull-up raises the wire, and the block adds a single cycle of active-high drive so the rise is quicker. To send a zero, the block holds the wire low past the sample point and then drives it high for one cycle before it lets go. A bit-done strobe marks the end of each slot. The block then takes no new falling edge until it has seen the wire high again.

Top module: `dbg_bit_tx`

## Requirements
- R1: While reset is active and after it is released, `line_oe` and `bit_done` are 0 until a bit starts. An active reset during a bit ends the drive at once.
- R2: The line input passes through a two-flop synchronizer and an edge detector. If the line falls between two rising edges, cycle 0 of the slot is the cycle that follows the third rising edge after the fall.
- R3: For a one bit (`bit_val`=1), `line_oe` is 1 only in cycle 7 of the slot, and `line_lvl` is 1 in that cycle.
- R4: For a zero bit (`bit_val`=0), `line_oe`=1 with `line_lvl`=0 in every cycle from 0 through 12.
- R5: For a zero bit, cycle 13 has `line_oe`=1 and `line_lvl`=1. From cycle 14 on, `line_oe` is 0.
- R6: `bit_done` is 1 for exactly one cycle, the cycle after the last driven cycle. That is cycle 8 for a one bit and cycle 14 for a zero bit.
- R7: `bit_val` and `send_en` are sampled only at the detected falling edge. Changes to them later in the slot do not change the output waveform.
- R8: A falling edge seen while `send_en`=0 starts no slot. The outputs stay at 0.
- R9: A falling edge during a slot, or before the synchronized line has been seen high after `bit_done`, starts no new slot. A line that rises and stays high starts nothing.
- R10: The active-high drive (`line_oe`=1 and `line_lvl`=1) never lasts more than one cycle in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Target clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | 1 | Level of the shared debug wire (asynchronous) |
| bit_val | input | 1 | Bit to send in the next slot |
| send_en | input | 1 | When 1, the next host falling edge starts a slot |
| line_oe | output | 1 | Drive enable for the wire (0 = high impedance) |
| line_lvl | output | 1 | Level driven while `line_oe` is 1 |
| bit_done | output | 1 | One-cycle strobe at the end of a slot |

## Verification
The assertions check, on every cycle, the rules that need no knowledge of which bit was requested:
- the speed-up drive never lasts two cycles in a row;
- the done strobe is one cycle wide and always follows a driven cycle;
- the wire is never driven outside a slot;
- the slot counter advances by exactly one per cycle, so an edge inside a slot cannot restart it;
- each slot begins at a detected edge with the counter at zero.

Only the bench scenarios can show the rest:
- the exact cycle numbers of the waveforms for each bit value;
- the three-edge latency from the line to cycle 0;
- that late changes to `bit_val` or `send_en` are ignored;
- that a line held low past the end of a slot starts nothing when it is released.

// File: rtl/dbg_bit_pkg.sv
package dbg_bit_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_DONE = 2'd2,
    ST_HOLD = 2'd3
  } tx_state_e;

  // Last cycle in which the wire is driven for the given bit.
  function automatic int last_drive_cycle(logic b, int one_at, int zero_last);
    return b ? one_at : zero_last + 1;
  endfunction

  // Drive enable for slot cycle c.
  function automatic logic drive_enable_at(logic b, int c, int one_at, int zero_last);
    if (b) return (c == one_at);
    return (c <= zero_last + 1);
  endfunction

  // Drive level for slot cycle c (meaningful only while enabled).
  function automatic logic drive_level_at(logic b, int c, int zero_last);
    if (b) return 1'b1;
    return (c == zero_last + 1);
  endfunction

endpackage

// File: rtl/dbg_line_sync.sv
module dbg_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_s_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= line_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], line_i};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign line_s_o = chain_q[STAGES-1];
  assign fall_o   = prev_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/dbg_drive_map.sv
module dbg_drive_map
  import dbg_bit_pkg::*;
#(
  parameter int ONE_AT    = 7,
  parameter int ZERO_LAST = 12,
  parameter int CNT_W     = 4
) (
  input  logic             active_i,
  input  logic             bit_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             oe_o,
  output logic             lvl_o,
  output logic             last_o
);

  int c;

  always_comb begin
    c      = int'(cnt_i);
    oe_o   = active_i & drive_enable_at(bit_i, c, ONE_AT, ZERO_LAST);
    lvl_o  = active_i & drive_level_at(bit_i, c, ZERO_LAST);
    last_o = active_i & (c == last_drive_cycle(bit_i, ONE_AT, ZERO_LAST));
  end

endmodule

// File: rtl/dbg_bit_seq.sv
module dbg_bit_seq
  import dbg_bit_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall_i,
  input  logic             line_s_i,
  input  logic             send_en_i,
  input  logic             bit_i,
  input  logic             last_i,
  output logic             active_o,
  output logic             bit_q_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);

  tx_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             bit_q, bit_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    unique case (state_q)
      ST_IDLE: begin
        if (fall_i && send_en_i) begin
          state_d = ST_SEND;
          cnt_d   = '0;
          bit_d   = bit_i;
        end
      end
      ST_SEND: begin
        if (last_i) state_d = ST_DONE;
        else        cnt_d   = cnt_q + CNT_W'(1);
      end
      ST_DONE: state_d = ST_HOLD;
      ST_HOLD: if (line_s_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
    end
  end

  assign active_o = (state_q == ST_SEND);
  assign bit_q_o  = bit_q;
  assign cnt_o    = cnt_q;
  assign done_o   = (state_q == ST_DONE);

endmodule

// File: rtl/dbg_bit_tx.sv
module dbg_bit_tx #(
  parameter int SYNC_STAGES = 2,
  parameter int ONE_AT      = 7,
  parameter int ZERO_LAST   = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic bit_val,
  input  logic send_en,
  output logic line_oe,
  output logic line_lvl,
  output logic bit_done
);

  localparam int MAX_CNT = (ONE_AT > ZERO_LAST + 1) ? ONE_AT : ZERO_LAST + 1;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  // Named internal events, also watched by the checker.
  logic             line_sync;
  logic             fall_seen;
  logic             seq_busy;
  logic             seq_bit;
  logic [CNT_W-1:0] seq_cnt;
  logic             last_drive;

  dbg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_i   (line_in),
    .line_s_o (line_sync),
    .fall_o   (fall_seen)
  );

  dbg_bit_seq #(.CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .fall_i    (fall_seen),
    .line_s_i  (line_sync),
    .send_en_i (send_en),
    .bit_i     (bit_val),
    .last_i    (last_drive),
    .active_o  (seq_busy),
    .bit_q_o   (seq_bit),
    .cnt_o     (seq_cnt),
    .done_o    (bit_done)
  );

  dbg_drive_map #(
    .ONE_AT    (ONE_AT),
    .ZERO_LAST (ZERO_LAST),
    .CNT_W     (CNT_W)
  ) u_map (
    .active_i (seq_busy),
    .bit_i    (seq_bit),
    .cnt_i    (seq_cnt),
    .oe_o     (line_oe),
    .lvl_o    (line_lvl),
    .last_o   (last_drive)
  );

endmodule

// File: rtl/dbg_bit_tx_chk.sv
module dbg_bit_tx_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             line_oe,
  input logic             line_lvl,
  input logic             bit_done,
  input logic             fall_seen,
  input logic             seq_busy,
  input logic [CNT_W-1:0] seq_cnt
);

  assert_pulse_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (line_oe && line_lvl) |=> !(line_oe && line_lvl));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_done |=> !bit_done);

  assert_done_after_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_done |-> $past(line_oe));

  assert_idle_undriven_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_busy |-> !line_oe);

  assert_count_steps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy && $past(seq_busy)) |-> (seq_cnt == $past(seq_cnt) + CNT_W'(1)));

  assert_start_from_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_busy) |-> ($past(fall_seen) && seq_cnt == '0));

endmodule

bind dbg_bit_tx dbg_bit_tx_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .line_oe   (line_oe),
  .line_lvl  (line_lvl),
  .bit_done  (bit_done),
  .fall_seen (fall_seen),
  .seq_busy  (seq_busy),
  .seq_cnt   (seq_cnt)
);

// File: tb/dbg_bit_tx_bench.sv
`timescale 1ns/1ps
module dbg_bit_tx_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_low = 1'b0;
  logic bit_val = 1'b0;
  logic send_en = 1'b0;
  logic line_oe, line_lvl, bit_done;
  wire  line_in;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  // Wired-AND model of the open-drain wire with a pull-up.
  assign line_in = !(host_low || (line_oe && !line_lvl));

  dbg_bit_tx u_dbg_bit_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_in  (line_in),
    .bit_val  (bit_val),
    .send_en  (send_en),
    .line_oe  (line_oe),
    .line_lvl (line_lvl),
    .bit_done (bit_done)
  );

  // Vector fields: {bit, enable, flip inputs mid-slot}
  localparam logic [2:0] VEC [6] = '{3'b110, 3'b010, 3'b111, 3'b011, 3'b100, 3'b000};

  task automatic check(string req, logic [2:0] act, logic [2:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: oe/lvl/done actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Expected waveform, stated directly from the requirements.
  function automatic logic [2:0] expect_at(logic b, logic en, int k);
    logic oe, lvl, dn;
    oe = 0; lvl = 0; dn = 0;
    if (en) begin
      if (b) begin
        oe = (k == 7); lvl = (k == 7); dn = (k == 8);
      end else begin
        oe = (k < 14); lvl = (k == 13); dn = (k == 14);
      end
    end
    return {oe, lvl, dn};
  endfunction

  // Host opens a slot; checks cycles 0..19.
  task automatic run_slot(logic b, logic en, logic flip, int relow_at, string req);
    @(negedge clk);
    bit_val = b; send_en = en; host_low = 1'b1;
    repeat (3) @(posedge clk);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      check(req, {line_oe, line_oe ? line_lvl : 1'b0, bit_done}, expect_at(b, en, k));
      if (k == 2) host_low = 1'b0;
      if (flip && k == 1) begin bit_val = ~b; send_en = ~en; end
      if (k == relow_at) host_low = 1'b1;
      if (k == relow_at + 3) host_low = 1'b0;
    end
    send_en = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_quiet(int n, string req);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check(req, {line_oe, line_lvl & line_oe, bit_done}, 3'b000);
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual=expired expected=complete");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 in reset", {line_oe, line_lvl, bit_done}, 3'b000);
    rst_n = 1'b1;
    check_quiet(4, "R1 after reset");

    // Table: R2 R3 R4 R5 R6 R7 R8
    foreach (VEC[i]) begin
      run_slot(VEC[i][2], VEC[i][1], VEC[i][0], 99,
               VEC[i][1] ? (VEC[i][0] ? "R7 inputs flipped" :
                            (VEC[i][2] ? "R3/R6 one bit R2" : "R4/R5/R6 zero bit"))
                         : "R8 disabled");
    end

    // R9: host pulls low again mid-slot; no restart
    run_slot(1'b1, 1'b1, 1'b0, 4, "R9 edge during slot");
    check_quiet(10, "R9 no restart after slot");

    // R9: host holds the wire low past bit_done, then releases
    @(negedge clk);
    bit_val = 1'b1; send_en = 1'b1; host_low = 1'b1;
    repeat (3) @(posedge clk);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      check("R9 held low", {line_oe, line_oe ? line_lvl : 1'b0, bit_done},
            expect_at(1'b1, 1'b1, k));
    end
    repeat (6) @(negedge clk);
    host_low = 1'b0;
    check_quiet(12, "R9 release starts nothing");

    // R10 / R1: reset in the middle of a zero slot
    @(negedge clk);
    bit_val = 1'b0; send_en = 1'b1; host_low = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); host_low = 1'b0;
    @(negedge clk);
    check("R4 before reset", {line_oe, line_lvl, bit_done}, 3'b100);
    rst_n = 1'b0;
    #1;
    check("R1 reset mid-slot", {line_oe, line_lvl, bit_done}, 3'b000);
    send_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check_quiet(20, "R1 quiet after reset");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule